// File: doc/BRIEF.md
# Backdoor Key Security Gate

This block decides whether a device is secured. The decision comes from a security configuration byte and an eight-byte stored key. Both are captured from non-volatile configuration while reset is held. Out of reset the device is secured unless the two-bit security field of that byte holds binary 10. While it is secured, debug reads of memory return a fixed blank pattern in place of real contents. The read-only view of the captured security byte is presented on an output, with its low field replaced by the effective state.

Software can lift the security for the rest of the current reset period. It issues the key-compare command together with eight candidate key bytes and a one-cycle launch strobe. A match opens the device. A mismatch locks out every later command until the next reset. No command changes the captured configuration. Reset always reloads the configuration, so a temporary unlock and a lockout are both undone by the next reset.

The comparison is either serial, one byte per cycle, or parallel in one cycle, chosen by a parameter. The command port is busy for the length of the comparison.

Top module: `secu_gate`

## Requirements
- R1: While `rst_n` is low the block captures `cfg_sec` and `cfg_key` on every clock. After release, `lockout` and `acc_err` are 0, `cmd_ready` is 1, and `sec_bits` equals the captured byte.
- R2: The effective security field is `sec_bits[1:0]`, and the device is open only when that field is 2'b10. `dbg_rd_en` is 1 exactly when the device is open. While it is 0, `dbg_rdata` carries BLANK_PAT (default 32'h5A5A5A5A); otherwise it carries `mem_rdata`.
- R3: A command is legal only if `cmd_code` is 8'h0C and the key-enable field `cfg_sec[7:6]` is 2'b10. An illegal launch sets `acc_err`, which then stays set until reset. It does not start a comparison and leaves `sec_bits` unchanged.
- R4: An accepted compare drops `cmd_ready` for CMP_CYCLES cycles: KEY_BYTES when serial, 1 when parallel. The result appears together with `cmd_ready` rising.
- R5: If all eight candidate bytes equal the stored bytes, `sec_bits[1:0]` becomes 2'b10 and stays there until reset.
- R6: A mismatch sets `lockout`, which stays set until reset, and leaves the security field unchanged.
- R7: While `lockout` is 1, every launch is ignored. `cmd_ready`, `acc_err` and `sec_bits` are unaffected.
- R8: A stored key whose bytes are all 8'h00 or all 8'hFF never matches, even when the candidate is identical to it.
- R9: A launch while `cmd_ready` is 0 is ignored and does not change the running comparison.
- R10: Asserting reset undoes an unlock, a lockout and an access error.
- R11: A configuration byte whose low field is 2'b10 leaves the device open straight out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_sec | input | 8 | Security configuration byte from non-volatile storage |
| cfg_key | input | 64 | Stored key, byte i at bits [8i+7:8i] |
| cmd_code | input | 8 | Command code |
| cmd_key | input | 64 | Candidate key, same byte layout as cfg_key |
| cmd_go | input | 1 | One-cycle launch strobe |
| mem_rdata | input | 32 | Raw memory read data |
| cmd_ready | output | 1 | High when no comparison is running |
| sec_bits | output | 8 | Read-only security byte; low two bits are the effective state |
| lockout | output | 1 | Set after a failed comparison |
| acc_err | output | 1 | Set after an illegal launch |
| dbg_rd_en | output | 1 | Debug reads return real data |
| dbg_rdata | output | 32 | Debug read data, blanked while secured |

## Verification
The hardest situations to reach are the ones layered on top of a comparison already in progress or already decided. Examples are a second launch landing in the middle of a serial compare, a correct key offered after a lockout, and an illegal code sent while locked. The stimulus reaches them by driving the strobe again at fixed cycle offsets after an accepted launch. It also covers stored keys of all-zero and all-one bytes with the identical candidate, which must still fail. A behavioural model compares every output on every clock.

// File: rtl/secu_pkg.sv
package secu_pkg;
   localparam int          CMD_W       = 8;
   localparam logic [7:0]  CMD_KEY_CMP = 8'h0C;
   localparam logic [1:0]  SEC_OPEN    = 2'b10;
   localparam logic [1:0]  KEYEN_ON    = 2'b10;
endpackage

// File: rtl/secu_cfg_regs.sv
module secu_cfg_regs #(
   parameter int KEY_BYTES = 8,
   parameter int BYTE_W    = 8,
   localparam int KW       = KEY_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cfg_sec,
   input  logic [KW-1:0]     cfg_key,
   output logic [BYTE_W-1:0] sec_q,
   output logic [KW-1:0]     key_q,
   output logic              key_bad
);
   // Capture configuration during reset; the captured values are read-only afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q   <= cfg_sec;
         key_q   <= cfg_key;
         key_bad <= (cfg_key == '0) || (&cfg_key);
      end
   end
endmodule

// File: rtl/secu_key_cmp.sv
module secu_key_cmp #(
   parameter int KEY_BYTES = 8,
   parameter int BYTE_W    = 8,
   parameter bit SERIAL    = 1'b1,
   localparam int KW       = KEY_BYTES * BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [KW-1:0] cand,
   input  logic [KW-1:0] key,
   input  logic          key_bad,
   output logic          busy,
   output logic          done,
   output logic          hit
);
   generate
      if (SERIAL) begin : g_serial
         localparam int IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
         localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_BYTES - 1);
         logic [KW-1:0]    cand_sh, key_sh;
         logic [IDX_W-1:0] idx;
         logic             miss, busy_q, miss_n;

         assign miss_n = miss | (cand_sh[BYTE_W-1:0] != key_sh[BYTE_W-1:0]);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_q  <= 1'b0;
               idx     <= '0;
               miss    <= 1'b0;
               cand_sh <= '0;
               key_sh  <= '0;
            end else if (busy_q) begin
               cand_sh <= cand_sh >> BYTE_W;
               key_sh  <= key_sh >> BYTE_W;
               miss    <= miss_n;
               idx     <= idx + 1'b1;
               if (idx == LAST) busy_q <= 1'b0;
            end else if (start) begin
               busy_q  <= 1'b1;
               idx     <= '0;
               miss    <= 1'b0;
               cand_sh <= cand;
               key_sh  <= key;
            end
         end

         assign busy = busy_q;
         assign done = busy_q && (idx == LAST);
         assign hit  = !miss_n && !key_bad;
      end else begin : g_parallel
         logic [KW-1:0] cand_q;
         logic          busy_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cand_q <= '0;
            end else if (busy_q) begin
               busy_q <= 1'b0;
            end else if (start) begin
               busy_q <= 1'b1;
               cand_q <= cand;
            end
         end

         assign busy = busy_q;
         assign done = busy_q;
         assign hit  = (cand_q == key) && !key_bad;
      end
   endgenerate
endmodule

// File: rtl/secu_state.sv
module secu_state
   import secu_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] sec_cfg,
   input  logic              cmd_go,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic              cmp_busy,
   input  logic              cmp_done,
   input  logic              cmp_hit,
   output logic              cmp_start,
   output logic [BYTE_W-1:0] sec_bits,
   output logic              lockout,
   output logic              acc_err,
   output logic              cmd_ready
);
   logic       unl_q, lock_q, err_q;
   logic       launch, legal;
   logic [1:0] keyen;

   assign keyen     = sec_cfg[BYTE_W-1 -: 2];
   assign launch    = cmd_go && !cmp_busy && !lock_q;
   assign legal     = (cmd_code == CMD_KEY_CMP) && (keyen == KEYEN_ON);
   assign cmp_start = launch && legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unl_q  <= 1'b0;
         lock_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (launch && !legal) err_q <= 1'b1;
         if (cmp_done) begin
            if (cmp_hit) unl_q  <= 1'b1;
            else         lock_q <= 1'b1;
         end
      end
   end

   assign sec_bits  = {sec_cfg[BYTE_W-1:2], unl_q ? SEC_OPEN : sec_cfg[1:0]};
   assign lockout   = lock_q;
   assign acc_err   = err_q;
   assign cmd_ready = !cmp_busy;
endmodule

// File: rtl/secu_blank.sv
module secu_blank
   import secu_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] BLANK_PAT = '0
) (
   input  logic [1:0]        sec_field,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rd_en,
   output logic [DATA_W-1:0] rdata
);
   assign rd_en = (sec_field == SEC_OPEN);
   assign rdata = rd_en ? mem_rdata : BLANK_PAT;
endmodule

// File: rtl/secu_gate.sv
module secu_gate
   import secu_pkg::*;
#(
   parameter int                KEY_BYTES  = 8,
   parameter int                BYTE_W     = 8,
   parameter int                DATA_W     = 32,
   parameter bit                SERIAL_CMP = 1'b1,
   parameter logic [DATA_W-1:0] BLANK_PAT  = {(DATA_W/8){8'h5A}},
   localparam int               KW         = KEY_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cfg_sec,
   input  logic [KW-1:0]     cfg_key,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic [KW-1:0]     cmd_key,
   input  logic              cmd_go,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cmd_ready,
   output logic [BYTE_W-1:0] sec_bits,
   output logic              lockout,
   output logic              acc_err,
   output logic              dbg_rd_en,
   output logic [DATA_W-1:0] dbg_rdata
);
   generate
      if (KEY_BYTES < 1 || BYTE_W < 4 || DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_param
         $error("secu_gate: unsupported parameter set");
      end
   endgenerate

   logic [BYTE_W-1:0] sec_q;
   logic [KW-1:0]     key_q;
   logic              key_bad, cmp_start, cmp_busy, cmp_done, cmp_hit;

   secu_cfg_regs #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_sec(cfg_sec), .cfg_key(cfg_key),
      .sec_q(sec_q), .key_q(key_q), .key_bad(key_bad)
   );

   secu_key_cmp #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W), .SERIAL(SERIAL_CMP)) u_cmp (
      .clk(clk), .rst_n(rst_n), .start(cmp_start), .cand(cmd_key), .key(key_q),
      .key_bad(key_bad), .busy(cmp_busy), .done(cmp_done), .hit(cmp_hit)
   );

   secu_state #(.BYTE_W(BYTE_W)) u_state (
      .clk(clk), .rst_n(rst_n), .sec_cfg(sec_q), .cmd_go(cmd_go), .cmd_code(cmd_code),
      .cmp_busy(cmp_busy), .cmp_done(cmp_done), .cmp_hit(cmp_hit),
      .cmp_start(cmp_start), .sec_bits(sec_bits), .lockout(lockout),
      .acc_err(acc_err), .cmd_ready(cmd_ready)
   );

   secu_blank #(.DATA_W(DATA_W), .BLANK_PAT(BLANK_PAT)) u_blank (
      .sec_field(sec_bits[1:0]), .mem_rdata(mem_rdata),
      .rd_en(dbg_rd_en), .rdata(dbg_rdata)
   );
endmodule

// File: rtl/secu_gate_chk.sv
module secu_gate_chk #(
   parameter int                BYTE_W    = 8,
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] BLANK_PAT = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_go,
   input logic [7:0]        cmd_code,
   input logic              cmd_ready,
   input logic [BYTE_W-1:0] sec_bits,
   input logic              lockout,
   input logic              acc_err,
   input logic              dbg_rd_en,
   input logic [DATA_W-1:0] dbg_rdata
);
   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!lockout && !acc_err && cmd_ready));
   // R2
   blank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_rd_en |-> (dbg_rdata == BLANK_PAT && sec_bits[1:0] != 2'b10));
   // R3
   acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);
   // R3
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && cmd_ready && !lockout && cmd_code != 8'h0C) |=> (acc_err && cmd_ready));
   // R5
   open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_bits[1:0] == 2'b10) |=> (sec_bits[1:0] == 2'b10));
   // R6
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> lockout);
   // R7
   locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lockout && cmd_go) |=> (cmd_ready && $stable(acc_err) && $stable(sec_bits)));
endmodule

bind secu_gate secu_gate_chk #(.BYTE_W(BYTE_W), .DATA_W(DATA_W), .BLANK_PAT(BLANK_PAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
   .sec_bits(sec_bits), .lockout(lockout), .acc_err(acc_err),
   .dbg_rd_en(dbg_rd_en), .dbg_rdata(dbg_rdata)
);

// File: tb/tb_secu_gate.sv
`timescale 1ns/1ps
module tb_secu_gate;
   localparam int LAT = 8;
   localparam logic [31:0] BLANK = 32'h5A5A5A5A;
   localparam logic [31:0] MEMV  = 32'h12345678;
   localparam logic [63:0] KEYA  = 64'h0123456789ABCDEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_sec = 8'h80;
   logic [63:0] cfg_key = KEYA;
   logic [7:0]  cmd_code = 8'h00;
   logic [63:0] cmd_key = '0;
   logic        cmd_go = 1'b0;
   logic [31:0] mem_rdata = MEMV;
   logic        cmd_ready, lockout, acc_err, dbg_rd_en;
   logic [7:0]  sec_bits;
   logic [31:0] dbg_rdata;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   secu_gate dut (
      .clk(clk), .rst_n(rst_n), .cfg_sec(cfg_sec), .cfg_key(cfg_key),
      .cmd_code(cmd_code), .cmd_key(cmd_key), .cmd_go(cmd_go), .mem_rdata(mem_rdata),
      .cmd_ready(cmd_ready), .sec_bits(sec_bits), .lockout(lockout), .acc_err(acc_err),
      .dbg_rd_en(dbg_rd_en), .dbg_rdata(dbg_rdata)
   );

   // Behavioural reference model
   logic [7:0]  m_cfg;
   logic [63:0] m_key;
   bit          m_unl, m_lock, m_acc, m_pend, m_valid = 1'b0;
   int          m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = cfg_sec; m_key = cfg_key;
         m_unl = 0; m_lock = 0; m_acc = 0; m_cnt = 0; m_valid = 1;
      end else if (m_cnt > 0) begin
         m_cnt = m_cnt - 1;
         if (m_cnt == 0) begin
            if (m_pend) m_unl = 1; else m_lock = 1;
         end
      end else if (cmd_go && !m_lock) begin
         if (cmd_code == 8'h0C && m_cfg[7:6] == 2'b10) begin
            m_cnt  = LAT;
            m_pend = (cmd_key == m_key) && (m_key != 64'h0) && (m_key != {64{1'b1}});
         end else begin
            m_acc = 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && m_valid && !finished) begin
         logic [1:0] es;
         es = m_unl ? 2'b10 : m_cfg[1:0];
         chk(cmd_ready == (m_cnt == 0), "R4 cmd_ready", 64'(cmd_ready), 64'(m_cnt == 0));
         chk(sec_bits == {m_cfg[7:2], es}, "R5 sec_bits", 64'(sec_bits), 64'({m_cfg[7:2], es}));
         chk(lockout == m_lock, "R6 lockout", 64'(lockout), 64'(m_lock));
         chk(acc_err == m_acc, "R3 acc_err", 64'(acc_err), 64'(m_acc));
         chk(dbg_rd_en == (es == 2'b10), "R2 dbg_rd_en", 64'(dbg_rd_en), 64'(es == 2'b10));
         chk(dbg_rdata == ((es == 2'b10) ? MEMV : BLANK), "R2 dbg_rdata",
             64'(dbg_rdata), 64'((es == 2'b10) ? MEMV : BLANK));
      end
   end

   task automatic do_reset(input logic [7:0] s, input logic [63:0] k);
      @(negedge clk);
      rst_n = 1'b0; cfg_sec = s; cfg_key = k; cmd_go = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic launch(input logic [7:0] c, input logic [63:0] k);
      cmd_code = c; cmd_key = k; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 40 && !cmd_ready; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      // R1 reset state, secured (field 00, key enable 10)
      do_reset(8'h80, KEYA);
      chk(!lockout && !acc_err && cmd_ready, "R1 reset flags", {lockout, acc_err, cmd_ready}, 3'b001);
      chk(sec_bits == 8'h80, "R1 sec_bits", 64'(sec_bits), 64'h80);
      chk(dbg_rdata == BLANK, "R2 blanked", 64'(dbg_rdata), 64'(BLANK));
      // R3 illegal code
      launch(8'h11, KEYA);
      chk(acc_err && sec_bits[1:0] == 2'b00, "R3 bad code", {acc_err, sec_bits[1:0]}, 3'b100);
      // R10 reset clears error; R4/R9/R5 good key with mid-compare launch
      do_reset(8'h80, KEYA);
      chk(!acc_err, "R10 acc cleared", 64'(acc_err), 0);
      launch(8'h0C, KEYA);
      n = 1;
      launch(8'h0C, 64'hFFFF);   // R9 ignored while busy
      n++;
      while (!cmd_ready && n < 40) begin @(negedge clk); n++; end
      chk(n == LAT + 1, "R4 busy length", 64'(n - 1), 64'(LAT));
      chk(sec_bits[1:0] == 2'b10 && !lockout, "R9 busy launch ignored", {sec_bits[1:0], lockout}, 3'b100);
      chk(dbg_rd_en && dbg_rdata == MEMV, "R5 open read", 64'(dbg_rdata), 64'(MEMV));
      // R10 unlock undone; R6 mismatch; R7 ignored after lockout
      do_reset(8'h80, KEYA);
      chk(sec_bits[1:0] == 2'b00, "R10 secured again", 64'(sec_bits[1:0]), 0);
      launch(8'h0C, KEYA ^ 64'h100);
      wait_ready();
      chk(lockout && sec_bits[1:0] == 2'b00, "R6 lockout", {lockout, sec_bits[1:0]}, 3'b100);
      launch(8'h0C, KEYA);
      chk(cmd_ready && sec_bits[1:0] == 2'b00, "R7 key ignored", {cmd_ready, sec_bits[1:0]}, 3'b100);
      launch(8'h33, KEYA);
      chk(!acc_err, "R7 bad code ignored", 64'(acc_err), 0);
      do_reset(8'h80, KEYA);
      chk(!lockout, "R10 lockout cleared", 64'(lockout), 0);
      // R3 key enable not 10
      do_reset(8'h40, KEYA);
      launch(8'h0C, KEYA);
      chk(acc_err && cmd_ready && sec_bits[1:0] == 2'b00, "R3 keyen off",
          {acc_err, cmd_ready, sec_bits[1:0]}, 4'b1100);
      // R8 blank keys
      do_reset(8'h80, {64{1'b1}});
      launch(8'h0C, {64{1'b1}});
      wait_ready();
      chk(lockout && sec_bits[1:0] == 2'b00, "R8 all-FF key", {lockout, sec_bits[1:0]}, 3'b100);
      do_reset(8'h80, 64'h0);
      launch(8'h0C, 64'h0);
      wait_ready();
      chk(lockout && !dbg_rd_en, "R8 all-00 key", {lockout, dbg_rd_en}, 2'b10);
      // R11 open from configuration
      do_reset(8'h02, KEYA);
      chk(sec_bits[1:0] == 2'b10 && dbg_rd_en, "R11 open at reset", {sec_bits[1:0], dbg_rd_en}, 3'b101);
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule